// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Controller

This block turns a single pulse-width command into two gate-enable outputs, one for the high-side switch and one for the low-side switch of a buck power stage. It does not insert a fixed delay between the two. Each turn-on is gated by feedback from the power stage. The high side may start only once the low-side gate level reads low. The low side may start only once the switch node reads low. A minimum number of clock cycles with both outputs off is also enforced.

Several controls sit above the normal switching, in a fixed priority. The active-low crowbar input forces the low side on and the high side off, whatever every other input says. An enable input that is low forces both outputs off and clears a latched fault. A latched fault also keeps both outputs off. When the mode input is low, the low side never turns on, which gives nonsynchronous operation. A watchdog raises the fault when the expected feedback fails to fall in time. All inputs cross two synchronizer flops before use. A parameter fixes whether the command is active high or active low.

Top module: `dtbridge_ctrl`

## Requirements
- R1: While reset is applied and directly after it, `hi_on`, `lo_on` and `fault` are 0.
- R2: When `crowbar_n` is 1 and `enable` is 0, both outputs are 0 and `fault` is cleared to 0.
- R3: When `crowbar_n` is 0, `lo_on` is 1 and `hi_on` is 0, regardless of `enable`, `fault` and `pwm_in`. A latched `fault` stays 1 through the crowbar.
- R4: When `sync_mode` is 0, `lo_on` is never raised by normal switching.
- R5: `hi_on` rises only when the synchronized `lo_gate_fb` was 0 in the cycle before.
- R6: Outside the crowbar, `lo_on` rises only when the synchronized `sw_node_fb` was 0 in the cycle before.
- R7: Between one output going off and `hi_on` rising, both outputs stay 0 for at least MIN_DEAD+1 clock cycles.
- R8: Every input reaches the control logic through two flops, so a change at an input moves the outputs on the third rising edge at the earliest. Turn-off needs no feedback and takes place on exactly that edge.
- R9: If a turn-on waits on high feedback for WD_LIMIT consecutive cycles, `fault` becomes 1. Both outputs then stay 0 (except under crowbar) until `enable` is taken low.
- R10: With PWM_INVERT=0 a 1 on `pwm_in` requests the high side. With PWM_INVERT=1 a 0 requests it.
- R11: `hi_on` and `lo_on` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Switching command; its polarity is set by PWM_INVERT |
| enable | input | 1 | 0 forces both outputs off and clears the fault |
| sync_mode | input | 1 | 1 = synchronous rectification, 0 = low side kept off |
| crowbar_n | input | 1 | Active-low override: low side on, high side off |
| lo_gate_fb | input | 1 | Sensed low-side gate level, 1 = still high |
| sw_node_fb | input | 1 | Sensed switch-node level, 1 = still high |
| hi_on | output | 1 | High-side gate enable |
| lo_on | output | 1 | Low-side gate enable |
| fault | output | 1 | Latched watchdog fault |

## Verification
The crowbar override and the watchdog fault can act in the same cycle. The bench latches a fault by holding the low-gate feedback high while the command asks for the high side. It then pulls the crowbar low and expects the low side on and the high side off with the fault still latched. After the crowbar is released it expects both outputs to return to off. The crowbar is also applied against a disabled block and against a running switching pattern. A behavioural reference model, fed with the same delayed inputs, judges every cycle of two instances of opposite command polarity.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
    // bit positions inside the synchronized input vector
    localparam int IDX_PWM  = 0;
    localparam int IDX_EN   = 1;
    localparam int IDX_SYNC = 2;
    localparam int IDX_CROW = 3;
    localparam int IDX_LOFB = 4;
    localparam int IDX_SWFB = 5;
    localparam int N_IN     = 6;
    // crowbar is active low, so it idles at 1 out of reset
    localparam logic [N_IN-1:0] IN_RST_VAL = 6'b00_1000;
endpackage

// File: rtl/dtb_sync.sv
module dtb_sync #(
    parameter int              W       = 6,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dtb_core.sv
module dtb_core
    import dtb_pkg::*;
#(
    parameter bit PWM_INVERT = 1'b0,
    parameter int MIN_DEAD   = 3,
    parameter int WD_LIMIT   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] s_vec,
    output logic            hi_on,
    output logic            lo_on,
    output logic            fault
);
    localparam int DW = $clog2(MIN_DEAD + 2);
    localparam int WW = $clog2(WD_LIMIT + 1);

    typedef struct packed {
        logic          hi;
        logic          lo;
        logic          fault;
        logic [DW-1:0] dead;
        logic [WW-1:0] wd;
    } core_t;

    core_t st_d, st_q;
    logic  cmd, want_hi, want_lo, both_off, dead_ok, waiting;

    always_comb begin
        cmd      = s_vec[IDX_PWM] ^ PWM_INVERT;
        want_hi  = cmd;
        want_lo  = !cmd && s_vec[IDX_SYNC];
        both_off = !st_q.hi && !st_q.lo;
        dead_ok  = (st_q.dead == DW'(MIN_DEAD));
        waiting  = both_off && ((want_hi && s_vec[IDX_LOFB]) ||
                                (want_lo && s_vec[IDX_SWFB]));

        st_d      = st_q;
        st_d.dead = both_off ? (dead_ok ? st_q.dead : st_q.dead + DW'(1)) : '0;

        if (!s_vec[IDX_CROW]) begin
            st_d.hi = 1'b0;
            st_d.lo = 1'b1;
            st_d.wd = '0;
        end else if (!s_vec[IDX_EN]) begin
            st_d.hi    = 1'b0;
            st_d.lo    = 1'b0;
            st_d.fault = 1'b0;
            st_d.wd    = '0;
        end else if (st_q.fault) begin
            st_d.hi = 1'b0;
            st_d.lo = 1'b0;
            st_d.wd = '0;
        end else begin
            st_d.hi = want_hi && (st_q.hi ||
                      (both_off && !s_vec[IDX_LOFB] && dead_ok));
            st_d.lo = want_lo && (st_q.lo ||
                      (both_off && !s_vec[IDX_SWFB] && dead_ok));
            if (waiting) begin
                if (st_q.wd == WW'(WD_LIMIT - 1)) begin
                    st_d.fault = 1'b1;
                    st_d.wd    = '0;
                end else begin
                    st_d.wd = st_q.wd + WW'(1);
                end
            end else begin
                st_d.wd = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_on = st_q.hi;
    assign lo_on = st_q.lo;
    assign fault = st_q.fault;

    // R11
    never_both_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_on && lo_on));

    // R3
    crowbar_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_vec[IDX_CROW] |=> (lo_on && !hi_on));

    // R2
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vec[IDX_CROW] && !s_vec[IDX_EN]) |=> (!hi_on && !lo_on && !fault));

    // R4
    async_lo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vec[IDX_CROW] && !s_vec[IDX_SYNC]) |=> !lo_on);

    // R5
    hi_gate_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_on) |-> !$past(s_vec[IDX_LOFB]));

    // R6
    lo_gate_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_on) |-> (!$past(s_vec[IDX_CROW]) || !$past(s_vec[IDX_SWFB])));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && s_vec[IDX_CROW]) |=> (!hi_on && !lo_on));
endmodule

// File: rtl/dtbridge_ctrl.sv
module dtbridge_ctrl
    import dtb_pkg::*;
#(
    parameter bit PWM_INVERT  = 1'b0,
    parameter int MIN_DEAD    = 3,
    parameter int WD_LIMIT    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic enable,
    input  logic sync_mode,
    input  logic crowbar_n,
    input  logic lo_gate_fb,
    input  logic sw_node_fb,
    output logic hi_on,
    output logic lo_on,
    output logic fault
);
    logic [N_IN-1:0] raw_vec, s_vec;

    always_comb begin
        raw_vec           = '0;
        raw_vec[IDX_PWM]  = pwm_in;
        raw_vec[IDX_EN]   = enable;
        raw_vec[IDX_SYNC] = sync_mode;
        raw_vec[IDX_CROW] = crowbar_n;
        raw_vec[IDX_LOFB] = lo_gate_fb;
        raw_vec[IDX_SWFB] = sw_node_fb;
    end

    dtb_sync #(
        .W       (N_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_RST_VAL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_vec),
        .dout  (s_vec)
    );

    dtb_core #(
        .PWM_INVERT (PWM_INVERT),
        .MIN_DEAD   (MIN_DEAD),
        .WD_LIMIT   (WD_LIMIT)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .s_vec (s_vec),
        .hi_on (hi_on),
        .lo_on (lo_on),
        .fault (fault)
    );
endmodule

// File: tb/test_dtbridge_ctrl.sv
module test_dtbridge_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_DEAD   = 3;
    localparam int WD_LIMIT   = 12;
    localparam logic [5:0] RSTV = 6'b001000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm = 1'b0, en = 1'b0, sy = 1'b1, crow_n = 1'b1;
    logic [1:0] lofb = '0, swfb = '0, hi_o, lo_o, flt_o;
    logic [1:0] f_lofb = '0, f_swfb = '0;
    bit   [1:0] auto_fb = 2'b11;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtbridge_ctrl #(.PWM_INVERT(1'b0), .MIN_DEAD(MIN_DEAD), .WD_LIMIT(WD_LIMIT)) i_dtbridge_ctrl (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .enable(en), .sync_mode(sy),
        .crowbar_n(crow_n), .lo_gate_fb(lofb[0]), .sw_node_fb(swfb[0]),
        .hi_on(hi_o[0]), .lo_on(lo_o[0]), .fault(flt_o[0]));

    dtbridge_ctrl #(.PWM_INVERT(1'b1), .MIN_DEAD(MIN_DEAD), .WD_LIMIT(WD_LIMIT)) i_dtbridge_ctrl_inv (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .enable(en), .sync_mode(sy),
        .crowbar_n(crow_n), .lo_gate_fb(lofb[1]), .sw_node_fb(swfb[1]),
        .hi_on(hi_o[1]), .lo_on(lo_o[1]), .fault(flt_o[1]));

    // reference model: inputs seen two edges late, behaviour from the requirements
    int m_hi[2], m_lo[2], m_flt[2], m_dead[2], m_wd[2];
    logic [5:0] h1[2], h2[2];
    logic [5:0] sv;
    int nh, nl, nf, nd, nw;
    bit cmd, wh, wl, boff;

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_hi[i] = 0; m_lo[i] = 0; m_flt[i] = 0; m_dead[i] = 0; m_wd[i] = 0;
            h1[i] = RSTV; h2[i] = RSTV;
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                m_hi[i] = 0; m_lo[i] = 0; m_flt[i] = 0; m_dead[i] = 0; m_wd[i] = 0;
                h1[i] = RSTV; h2[i] = RSTV;
            end else begin
                sv   = h2[i];
                cmd  = sv[0] ^ (i == 1);
                wh   = cmd;
                wl   = !cmd && sv[2];
                boff = (m_hi[i] == 0) && (m_lo[i] == 0);
                nd   = boff ? ((m_dead[i] == MIN_DEAD) ? m_dead[i] : m_dead[i] + 1) : 0;
                nh = m_hi[i]; nl = m_lo[i]; nf = m_flt[i]; nw = m_wd[i];
                if (!sv[3]) begin
                    nh = 0; nl = 1; nw = 0;
                end else if (!sv[1]) begin
                    nh = 0; nl = 0; nf = 0; nw = 0;
                end else if (m_flt[i] != 0) begin
                    nh = 0; nl = 0; nw = 0;
                end else begin
                    nh = (wh && (m_hi[i] != 0 || (boff && !sv[4] && m_dead[i] == MIN_DEAD))) ? 1 : 0;
                    nl = (wl && (m_lo[i] != 0 || (boff && !sv[5] && m_dead[i] == MIN_DEAD))) ? 1 : 0;
                    if (boff && ((wh && sv[4]) || (wl && sv[5]))) begin
                        if (m_wd[i] + 1 >= WD_LIMIT) begin nf = 1; nw = 0; end
                        else nw = m_wd[i] + 1;
                    end else nw = 0;
                end
                m_hi[i] = nh; m_lo[i] = nl; m_flt[i] = nf; m_dead[i] = nd; m_wd[i] = nw;
                h2[i] = h1[i];
                h1[i] = {swfb[i], lofb[i], crow_n, sy, en, pwm};
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, plant feedback and dead-gap measurement
    int gap = 1000;
    logic prev_hi = 1'b0;
    always @(negedge clk) begin
        if (!done) begin
            for (int i = 0; i < 2; i++) begin
                chk(hi_o[i], m_hi[i] != 0, $sformatf("R8 model hi inst%0d", i));
                chk(lo_o[i], m_lo[i] != 0, $sformatf("R8 model lo inst%0d", i));
                chk(flt_o[i], m_flt[i] != 0, $sformatf("R9 model fault inst%0d", i));
                chk(hi_o[i] && lo_o[i], 1'b0, $sformatf("R11 overlap inst%0d", i));
            end
            if (hi_o[0] && !prev_hi) chk(gap >= MIN_DEAD + 1, 1'b1, "R7 dead gap");
            gap     = (hi_o[0] || lo_o[0]) ? 0 : gap + 1;
            prev_hi = hi_o[0];
            for (int i = 0; i < 2; i++) begin
                lofb[i] <= auto_fb[i] ? lo_o[i] : f_lofb[i];
                swfb[i] <= auto_fb[i] ? hi_o[i] : f_swfb[i];
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog timeout actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(4);
        chk(hi_o[0], 1'b0, "R1 reset hi");
        chk(lo_o[0], 1'b0, "R1 reset lo");
        chk(flt_o[0], 1'b0, "R1 reset fault");
        rst_n = 1'b1;
        cyc(3);
        chk(hi_o[0] | lo_o[0] | flt_o[0], 1'b0, "R1 after reset");

        en = 1'b1; sy = 1'b1;
        for (int k = 0; k < 6; k++) begin
            pwm = 1'b1; cyc(15 + k);
            chk(hi_o[0], 1'b1, "R8 high phase hi");
            chk(lo_o[0], 1'b0, "R8 high phase lo");
            chk(lo_o[1], 1'b1, "R10 inverted lo on command 1");
            pwm = 1'b0; cyc(15 + k);
            chk(lo_o[0], 1'b1, "R8 low phase lo");
            chk(hi_o[1], 1'b1, "R10 inverted hi on command 0");
        end

        // exact turn-off latency: third rising edge after input change
        pwm = 1'b1; cyc(2);
        chk(lo_o[0], 1'b1, "R8 lo still on after two edges");
        cyc(1);
        chk(lo_o[0], 1'b0, "R8 lo off on third edge");
        cyc(15);

        sy = 1'b0;
        for (int k = 0; k < 3; k++) begin
            pwm = 1'b0; cyc(16);
            chk(lo_o[0], 1'b0, "R4 async low phase lo");
            chk(hi_o[0], 1'b0, "R4 async low phase hi");
            pwm = 1'b1; cyc(16);
            chk(hi_o[0], 1'b1, "R4 async high phase hi");
        end
        sy = 1'b1; pwm = 1'b0; cyc(20);

        // high side waits on low-gate feedback
        f_lofb[0] = 1'b1; f_swfb[0] = 1'b0; auto_fb[0] = 1'b0;
        pwm = 1'b1; cyc(8);
        chk(hi_o[0], 1'b0, "R5 hi held by low-gate feedback");
        f_lofb[0] = 1'b0; cyc(6);
        chk(hi_o[0], 1'b1, "R5 hi after feedback low");

        // low side waits on switch-node feedback
        f_swfb[0] = 1'b1; pwm = 1'b0; cyc(8);
        chk(lo_o[0], 1'b0, "R6 lo held by switch node");
        chk(hi_o[0], 1'b0, "R6 hi off");
        f_swfb[0] = 1'b0; cyc(6);
        chk(lo_o[0], 1'b1, "R6 lo after switch node low");

        // watchdog fault
        f_lofb[0] = 1'b1; pwm = 1'b1; cyc(25);
        chk(flt_o[0], 1'b1, "R9 fault raised");
        chk(hi_o[0] | lo_o[0], 1'b0, "R9 outputs off in fault");
        f_lofb[0] = 1'b0; cyc(8);
        chk(flt_o[0], 1'b1, "R9 fault latched");
        chk(hi_o[0], 1'b0, "R9 hi held off");
        en = 1'b0; cyc(4);
        chk(flt_o[0], 1'b0, "R2 fault cleared by enable low");
        chk(hi_o[0] | lo_o[0], 1'b0, "R2 outputs off when disabled");
        en = 1'b1; cyc(15);
        chk(hi_o[0], 1'b1, "R9 recovery after enable toggle");

        // crowbar overrides running switching and disable
        auto_fb[0] = 1'b1;
        crow_n = 1'b0; cyc(4);
        chk(lo_o[0], 1'b1, "R3 crowbar lo");
        chk(hi_o[0], 1'b0, "R3 crowbar hi");
        chk(lo_o[1], 1'b1, "R3 crowbar lo inverted");
        en = 1'b0; cyc(4);
        chk(lo_o[0], 1'b1, "R3 crowbar over disable");
        crow_n = 1'b1; cyc(4);
        chk(lo_o[0], 1'b0, "R2 disabled after crowbar release");

        // crowbar and fault together
        en = 1'b1; auto_fb[0] = 1'b0; f_lofb[0] = 1'b1; f_swfb[0] = 1'b0;
        pwm = 1'b1; cyc(25);
        chk(flt_o[0], 1'b1, "R9 fault before crowbar");
        crow_n = 1'b0; cyc(4);
        chk(lo_o[0], 1'b1, "R3 crowbar lo during fault");
        chk(hi_o[0], 1'b0, "R3 crowbar hi during fault");
        chk(flt_o[0], 1'b1, "R3 fault kept through crowbar");
        crow_n = 1'b1; cyc(4);
        chk(hi_o[0] | lo_o[0], 1'b0, "R9 off after crowbar with fault");
        f_lofb[0] = 1'b0; auto_fb[0] = 1'b1;
        en = 1'b0; cyc(4);
        en = 1'b1; cyc(15);
        chk(hi_o[0], 1'b1, "R9 final recovery");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule